// File: doc/BRIEF.md
# Serial EEPROM Slave Controller

This block is an SPI slave (mode 0: SCK idles low, data sampled on the rising edge, MSB first) that presents itself to a host as a small serial EEPROM of 512 bytes. The chip select, serial clock and serial input come from the pins. They are brought into the block clock domain through two-stage synchronizers, and their edges are detected there. Five instructions are understood: set the write-enable latch, read status, write status, read memory and write memory.

Write data is collected in a 16-byte page buffer. When chip select returns high on a byte boundary, a timed internal programming cycle starts, and the buffered bytes are copied into the register array when that cycle ends. A status byte shows whether programming is in progress, whether the write-enable latch is set and which block-protect level is selected. The protect level fences off the top quarter, the top half or all of the array against writes.

A host uses the block like a serial memory part. It sets the latch, sends a page of data, then polls the status byte until the busy bit drops.

Top module: `spi_eeprom`

## Requirements
- R1: After reset the status byte reads 0x00, the serial output is not enabled, and every memory byte reads 0xFF.
- R2: Opcode 0x06 sets the write-enable latch. Opcode 0x05 returns the status byte repeatedly while chip select stays low. Status layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protect level, bits 7:4 zero.
- R3: Opcode {4'b0000, A8, 3'b010} is followed by address byte A7..A0 and then data bytes. A single data byte lands at the 9-bit address, so bit 3 of the opcode selects the upper 256 bytes.
- R4: A write opcode sent while the write-enable latch is clear is ignored, and memory and status stay unchanged.
- R5: When chip select rises after at least one complete data byte, status bit 0 reads 1 until the programming cycle of WRITE_CYCLES clocks has elapsed. It then reads 0.
- R6: While programming is in progress, every opcode except 0x05 is ignored: a status write leaves the protect bits unchanged, and a read never enables the serial output.
- R7: Within one write, each data byte advances only the low 4 address bits and the upper 5 bits stay fixed. Bytes beyond 16 wrap to the start of the same page and overwrite earlier bytes, and the neighbouring page is untouched.
- R8: The write-enable latch is cleared when the programming cycle completes.
- R9: Opcode 0x01 followed by a data byte, with the latch set, copies data bits 3:2 into the protect level and clears the latch. No other status bit is affected.
- R10: Protect level 1 blocks writes to 0x180-0x1FF, level 2 blocks 0x100-0x1FF and level 3 blocks all addresses. A blocked write changes no memory, starts no busy period and leaves the latch set.
- R11: If chip select rises in the middle of a data byte, or before any data byte, the write is dropped. No busy period starts, memory is unchanged and the latch stays set.
- R12: Opcode {4'b0000, A8, 3'b011} plus an address byte returns consecutive bytes, wrapping from 0x1FF to 0x000. The serial output enable is high only during read-data and status-data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block, driven low when not enabled |
| spi_so_oe | output | 1 | Output enable for spi_so |

## Verification
The write path is exercised with three patterns:
- a single byte in the upper half, which separates the A8 opcode bit from the address byte;
- a 20-byte burst starting mid-page, whose expected image shows whether the pointer wraps within the page or runs on into the next one;
- sequences cut short mid-byte or after the address, which separate an aborted write from a committed one.

Reads that straddle 0x1FF check the wrap at the end of memory. Commands issued while programming is in progress show whether the busy lockout covers both the status write and the read. Each protect level is tried against a blocked address, and level 1 is also tried against an address just below its boundary.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] A8_FIELD = 8'h08;

  typedef enum logic [2:0] {
    ST_OP, ST_WADDR, ST_WDATA, ST_RADDR, ST_RDATA, ST_STAT, ST_WRSR, ST_SKIP
  } cmd_state_t;

  // memory opcodes carry address bit 8 in bit 3, so compare with it masked
  function automatic logic op_match(input logic [7:0] op, input logic [7:0] code);
    return (op & ~A8_FIELD) == code;
  endfunction

  // advance the in-page offset only; the page number is held
  function automatic logic [15:0] page_step(input logic [15:0] a, input logic [15:0] pmask);
    return (a & ~pmask) | ((a + 16'd1) & pmask);
  endfunction

  // lowest address fenced by a protect level
  function automatic logic [15:0] lock_base(input logic [1:0] lvl, input logic [15:0] size);
    case (lvl)
      2'd1:    return size - (size >> 2);
      2'd2:    return size >> 1;
      2'd3:    return 16'd0;
      default: return size;
    endcase
  endfunction

  function automatic logic addr_locked(input logic [1:0] lvl, input logic [15:0] a,
                                       input logic [15:0] size);
    return (lvl != 2'd0) && (a >= lock_base(lvl, size));
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic wel,
                                             input logic [1:0] lvl);
    return {4'b0000, lvl, wel, busy};
  endfunction

endpackage

// File: rtl/spi_eeprom_link.sv
module spi_eeprom_link #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              si_i,
  input  logic              out_active_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              sel_o,
  output logic              cs_rise_o,
  output logic              aligned_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              tx_load_o,
  output logic              so_o,
  output logic              so_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [1:0] cs_sy, sck_sy, si_sy;
  logic       cs_d, sck_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] sh_in, tx_sh;
  logic              so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy  <= 2'b11;
      sck_sy <= 2'b00;
      si_sy  <= 2'b00;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[0], cs_n_i};
      sck_sy <= {sck_sy[0], sck_i};
      si_sy  <= {si_sy[0], si_i};
      cs_d   <= cs_sy[1];
      sck_d  <= sck_sy[1];
    end
  end

  wire sck_rise = sel_o && sck_sy[1] && !sck_d;
  wire sck_fall = sel_o && !sck_sy[1] && sck_d;

  assign sel_o     = !cs_sy[1];
  assign cs_rise_o = cs_sy[1] && !cs_d;
  assign aligned_o = (bit_cnt == '0);
  assign tx_load_o = sck_fall && aligned_o && out_active_i;
  assign so_oe_o   = sel_o && out_active_i;
  assign so_o      = so_oe_o ? so_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh_in      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
      tx_sh      <= '0;
      so_q       <= 1'b0;
    end else begin
      rx_valid_o <= sck_rise && (bit_cnt == LAST_BIT);
      if (!sel_o) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        bit_cnt <= bit_cnt + CNT_W'(1);
        sh_in   <= {sh_in[BYTE_W-2:0], si_sy[1]};
        if (bit_cnt == LAST_BIT) rx_byte_o <= {sh_in[BYTE_W-2:0], si_sy[1]};
      end
      if (tx_load_o) begin
        so_q  <= tx_byte_i[BYTE_W-1];
        tx_sh <= {tx_byte_i[BYTE_W-2:0], 1'b0};
      end else if (sck_fall) begin
        so_q  <= tx_sh[BYTE_W-1];
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R12: the output is never enabled while the chip is deselected
  assert_oe_needs_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sy[1] |-> !so_oe_o);

endmodule

// File: rtl/spi_eeprom_store.sv
module spi_eeprom_store #(
  parameter int ADDR_W       = 9,
  parameter int PAGE_W       = 4,
  parameter int WRITE_CYCLES = 64,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr_i,
  input  logic              buf_we_i,
  input  logic [PAGE_W-1:0] buf_idx_i,
  input  logic [7:0]        buf_data_i,
  input  logic              start_i,
  input  logic [ADDR_W-PAGE_W-1:0] start_page_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);

  logic [TMR_W-1:0]        tmr;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [7:0]              slot_data [SLOTS];
  logic [SLOTS-1:0]        slot_full;
  logic [7:0]              cell_out  [DEPTH];

  assign done_o    = busy_o && (tmr == '0);
  assign rd_data_o = cell_out[rd_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      tmr    <= '0;
      page_q <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      tmr    <= TMR_W'(WRITE_CYCLES - 1);
      page_q <= start_page_i;
    end else if (busy_o) begin
      if (done_o) busy_o <= 1'b0;
      else        tmr    <= tmr - TMR_W'(1);
    end
  end

  for (genvar p = 0; p < SLOTS; p++) begin : g_slot
    logic [7:0] data_q;
    logic       full_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        full_q <= 1'b0;
      end else begin
        if (buf_clr_i) full_q <= 1'b0;
        if (buf_we_i && buf_idx_i == PAGE_W'(p)) begin
          data_q <= buf_data_i;
          full_q <= 1'b1;
        end
      end
    end
    assign slot_data[p] = data_q;
    assign slot_full[p] = full_q;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(e);
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= ERASED;
      else if (done_o && page_q == EA[ADDR_W-1:PAGE_W] && slot_full[EA[PAGE_W-1:0]])
        cell_q <= slot_data[EA[PAGE_W-1:0]];
    end
    assign cell_out[e] = cell_q;
  end

  // R5: a programming cycle shows busy the clock after it is launched
  assert_busy_follows_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R6: nothing can launch a second cycle on top of a running one
  assert_no_start_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int MEM_BYTES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cs_rise_i,
  input  logic              aligned_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_load_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [7:0]        rd_data_i,
  output logic              out_active_o,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              buf_clr_o,
  output logic              buf_we_o,
  output logic [PAGE_W-1:0] buf_idx_o,
  output logic [7:0]        buf_data_o,
  output logic              start_o,
  output logic [ADDR_W-PAGE_W-1:0] start_page_o
);
  localparam logic [15:0] SIZE16 = 16'(MEM_BYTES);
  localparam logic [15:0] PMASK  = 16'((1 << PAGE_W) - 1);

  cmd_state_t        st;
  logic [ADDR_W-1:0] addr;
  logic              wel, a8_q, got_q;
  logic [1:0]        lvl;

  wire [7:0] status   = status_byte(busy_i, wel, lvl);
  wire op_stage       = rx_valid_i && (st == ST_OP);
  wire wr_accept      = op_stage && !busy_i && wel && op_match(rx_byte_i, OP_WRITE);
  wire page_locked    = addr_locked(lvl, 16'({addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}}), SIZE16);

  assign start_o      = cs_rise_i && (st == ST_WDATA) && aligned_i && got_q && !page_locked;
  assign start_page_o = addr[ADDR_W-1:PAGE_W];
  assign buf_clr_o    = wr_accept;
  assign buf_we_o     = rx_valid_i && (st == ST_WDATA);
  assign buf_idx_o    = addr[PAGE_W-1:0];
  assign buf_data_o   = rx_byte_i;
  assign out_active_o = (st == ST_RDATA) || (st == ST_STAT);
  assign tx_byte_o    = (st == ST_STAT) ? status : rd_data_i;
  assign rd_addr_o    = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_OP;
      addr  <= '0;
      wel   <= 1'b0;
      lvl   <= 2'd0;
      a8_q  <= 1'b0;
      got_q <= 1'b0;
    end else begin
      if (done_i) wel <= 1'b0;
      if (!sel_i) begin
        st <= ST_OP;
      end else if (rx_valid_i) begin
        unique case (st)
          ST_OP: begin
            a8_q <= rx_byte_i[3];
            if (busy_i && rx_byte_i != OP_RDSR) st <= ST_SKIP;
            else if (rx_byte_i == OP_RDSR) st <= ST_STAT;
            else if (rx_byte_i == OP_WREN) begin
              wel <= 1'b1;
              st  <= ST_SKIP;
            end
            else if (rx_byte_i == OP_WRSR) st <= wel ? ST_WRSR : ST_SKIP;
            else if (wr_accept) begin
              got_q <= 1'b0;
              st    <= ST_WADDR;
            end
            else if (op_match(rx_byte_i, OP_READ)) st <= ST_RADDR;
            else st <= ST_SKIP;
          end
          ST_WADDR: begin
            addr <= ADDR_W'({a8_q, rx_byte_i});
            st   <= ST_WDATA;
          end
          ST_RADDR: begin
            addr <= ADDR_W'({a8_q, rx_byte_i});
            st   <= ST_RDATA;
          end
          ST_WDATA: begin
            addr  <= ADDR_W'(page_step(16'(addr), PMASK));
            got_q <= 1'b1;
          end
          ST_WRSR: begin
            lvl <= rx_byte_i[3:2];
            wel <= 1'b0;
            st  <= ST_SKIP;
          end
          default: ;
        endcase
      end else if (tx_load_i && st == ST_RDATA) begin
        addr <= addr + ADDR_W'(1);
      end
    end
  end

  // R4: a programming cycle is only launched with the latch set
  assert_start_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> wel);
  // R6: no page buffer load while the array is busy
  assert_no_load_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !buf_we_o);
  // R7: storing a data byte never moves the page number
  assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |=> $stable(addr[ADDR_W-1:PAGE_W]));
  // R8: completion of programming drops the latch
  assert_wel_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !wel);
  // R9: protect bits move only on a completed status-write data byte
  assert_lvl_only_by_wrsr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(rx_valid_i && st == ST_WRSR));

endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom #(
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_si,
  output logic spi_so,
  output logic spi_so_oe
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic sel, cs_rise, aligned, rx_valid, tx_load, out_active;
  logic busy, done, buf_clr, buf_we, start;
  logic [7:0] rx_byte, tx_byte, rd_data, buf_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [PAGE_W-1:0] buf_idx;
  logic [ADDR_W-PAGE_W-1:0] start_page;

  spi_eeprom_link #(.BYTE_W(8)) u_link (
    .clk, .rst_n,
    .cs_n_i(spi_cs_n), .sck_i(spi_sck), .si_i(spi_si),
    .out_active_i(out_active), .tx_byte_i(tx_byte),
    .sel_o(sel), .cs_rise_o(cs_rise), .aligned_o(aligned),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .tx_load_o(tx_load),
    .so_o(spi_so), .so_oe_o(spi_so_oe)
  );

  spi_eeprom_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .MEM_BYTES(MEM_BYTES)) u_ctrl (
    .clk, .rst_n,
    .sel_i(sel), .cs_rise_i(cs_rise), .aligned_i(aligned),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .tx_load_i(tx_load),
    .busy_i(busy), .done_i(done), .rd_data_i(rd_data),
    .out_active_o(out_active), .tx_byte_o(tx_byte), .rd_addr_o(rd_addr),
    .buf_clr_o(buf_clr), .buf_we_o(buf_we), .buf_idx_o(buf_idx), .buf_data_o(buf_data),
    .start_o(start), .start_page_o(start_page)
  );

  spi_eeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
    .clk, .rst_n,
    .buf_clr_i(buf_clr), .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
    .start_i(start), .start_page_i(start_page),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done)
  );

endmodule

// File: tb/spi_eeprom_tb.sv
module spi_eeprom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WCYC       = 1000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  wire  so, so_oe;
  int   checks = 0, fails = 0;
  bit   finished = 1'b0;
  logic [7:0] wdat [0:31];
  logic [7:0] rdat [0:31];
  logic [7:0] expect_pg [0:15];
  logic hdr_oe, dat_oe_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_off;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  // shift nbits of tx (MSB first), sample SO before each rising edge
  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    rx = '0; oe_any = 1'b0; oe_all = 1'b1;
    for (int i = 7; i >= 8 - nbits; i--) begin
      si = tx[i];
      wait_clk(HALF);
      rx[i] = so;
      oe_any = oe_any | so_oe;
      oe_all = oe_all & so_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] r; logic a, b;
    xfer(tx, 8, r, a, b);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel_on; send(op); sel_off;
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic a, b;
    sel_on; send(8'h05); xfer(8'h00, 8, st, a, b); sel_off;
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel_on; send(8'h01); send(v); sel_off;
  endtask

  task automatic write_n(input logic [8:0] a, input int n);
    sel_on;
    send({4'b0000, a[8], 3'b010});
    send(a[7:0]);
    for (int i = 0; i < n; i++) send(wdat[i]);
    sel_off;
  endtask

  task automatic write1(input logic [8:0] a, input logic [7:0] d);
    wdat[0] = d;
    write_n(a, 1);
  endtask

  task automatic read_n(input logic [8:0] a, input int n);
    logic [7:0] r; logic any, all;
    sel_on;
    xfer({4'b0000, a[8], 3'b011}, 8, r, hdr_oe, all);
    xfer(a[7:0], 8, r, any, all);
    hdr_oe = hdr_oe | any;
    dat_oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, rdat[i], any, all);
      dat_oe_all = dat_oe_all & all;
    end
    sel_off;
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] st;
    for (int k = 0; k < 60; k++) begin
      rdsr(st);
      if (!st[0]) break;
    end
    check(tag, {15'd0, st[0]}, 16'd0);
  endtask

  task automatic t_reset;
    logic [7:0] st;
    rdsr(st);
    check("R1 status after reset", st, 8'h00);
    read_n(9'h0AB, 1);
    check("R1 erased byte", rdat[0], 8'hFF);
    check("R12 oe low in header", hdr_oe, 1'b0);
    check("R12 oe high in data", dat_oe_all, 1'b1);
  endtask

  task automatic t_no_wel;
    logic [7:0] st;
    write1(9'h010, 8'h55);
    rdsr(st);
    check("R4 status after unlatched write", st, 8'h00);
    read_n(9'h010, 1);
    check("R4 memory unchanged", rdat[0], 8'hFF);
  endtask

  task automatic t_byte_write;
    logic [7:0] st;
    cmd1(8'h06);
    rdsr(st);
    check("R2 latch set", st, 8'h02);
    write1(9'h1A5, 8'h96);
    rdsr(st);
    check("R5 busy with latch", st, 8'h03);
    wait_ready("R5 busy drops");
    rdsr(st);
    check("R8 latch cleared", st, 8'h00);
    read_n(9'h1A5, 1);
    check("R3 byte at upper address", rdat[0], 8'h96);
    read_n(9'h0A5, 1);
    check("R3 A8 separates halves", rdat[0], 8'hFF);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] st;
    cmd1(8'h06);
    write1(9'h033, 8'h44);
    wrsr(8'h0C);
    read_n(9'h033, 1);
    check("R6 read during busy keeps oe low", {15'd0, hdr_oe | dat_oe_all}, 16'd0);
    wait_ready("R6 busy drops");
    rdsr(st);
    check("R6 status write ignored", st, 8'h00);
    read_n(9'h033, 1);
    check("R6 first write landed", rdat[0], 8'h44);
  endtask

  task automatic t_page_wrap;
    for (int i = 0; i < 16; i++) expect_pg[i] = 8'hFF;
    for (int i = 0; i < 20; i++) begin
      wdat[i] = 8'h30 + 8'(i);
      expect_pg[(7 + i) % 16] = 8'h30 + 8'(i);
    end
    cmd1(8'h06);
    write_n(9'h047, 20);
    wait_ready("R7 busy drops");
    read_n(9'h040, 16);
    for (int i = 0; i < 16; i++) check($sformatf("R7 page offset %0d", i), rdat[i], expect_pg[i]);
    read_n(9'h050, 1);
    check("R7 next page untouched", rdat[0], 8'hFF);
  endtask

  task automatic t_read_wrap;
    cmd1(8'h06);
    write1(9'h1FF, 8'hC3);
    wait_ready("R5 busy drops");
    cmd1(8'h06);
    write1(9'h000, 8'h3C);
    wait_ready("R5 busy drops");
    read_n(9'h1FF, 3);
    check("R12 last byte", rdat[0], 8'hC3);
    check("R12 wrap to zero", rdat[1], 8'h3C);
    check("R12 after wrap", rdat[2], 8'hFF);
    check("R12 oe in data", dat_oe_all, 1'b1);
  endtask

  task automatic t_abort;
    logic [7:0] st, r; logic a, b;
    cmd1(8'h06);
    sel_on; send(8'h02); send(8'h20); xfer(8'hAA, 4, r, a, b); sel_off;
    rdsr(st);
    check("R11 mid-byte abort", st, 8'h02);
    read_n(9'h020, 1);
    check("R11 memory unchanged", rdat[0], 8'hFF);
    sel_on; send(8'h02); send(8'h21); sel_off;
    rdsr(st);
    check("R11 no data abort", st, 8'h02);
  endtask

  task automatic t_wrsr_protect;
    logic [7:0] st;
    wrsr(8'hFF);
    rdsr(st);
    check("R9 only protect bits", st, 8'h0C);
    cmd1(8'h06);
    write1(9'h000, 8'h11);
    rdsr(st);
    check("R10 level 3 blocks, latch kept", st, 8'h0E);
    read_n(9'h000, 1);
    check("R10 level 3 memory kept", rdat[0], 8'h3C);
    wrsr(8'h04);
    cmd1(8'h06);
    write1(9'h180, 8'h88);
    rdsr(st);
    check("R10 level 1 blocks top quarter", st, 8'h06);
    read_n(9'h180, 1);
    check("R10 level 1 memory kept", rdat[0], 8'hFF);
    write1(9'h170, 8'h77);
    rdsr(st);
    check("R10 level 1 allows below", st, 8'h07);
    wait_ready("R10 busy drops");
    read_n(9'h170, 1);
    check("R10 allowed write landed", rdat[0], 8'h77);
    cmd1(8'h06);
    wrsr(8'h08);
    cmd1(8'h06);
    write1(9'h100, 8'h12);
    rdsr(st);
    check("R10 level 2 blocks upper half", st, 8'h0A);
    read_n(9'h100, 1);
    check("R10 level 2 memory kept", rdat[0], 8'hFF);
    wrsr(8'h00);
    rdsr(st);
    check("R9 level cleared with latch", st, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_no_wel;
    t_byte_write;
    t_busy_ignore;
    t_page_wrap;
    t_read_wrap;
    t_abort;
    t_wrsr_protect;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule